// File: doc/BRIEF.md
# Multicore Interrupt Router

This block gathers the interrupt sources belonging to four processor cores and turns them into one IRQ line and one FIQ line per core. Each core contributes four local timer request levels, and a companion mailbox bank supplies a 16-bit vector that flags which of the four mailboxes of each core currently hold a nonzero value. One shared upstream IRQ line and one shared upstream FIQ line come from a peripheral interrupt controller. Each of these two lines is steered to a core chosen by software.

For every core, a pair of 8-bit control registers decides where each local source goes. One register covers the timer sources and one covers the mailboxes. Each source can be masked, sent to the IRQ side or sent to the FIQ side. The FIQ choice always overrides the IRQ choice. The block builds a pending IRQ word and a pending FIQ word for every core from the current input levels. Software can read these words, and a core's output line is raised one clock after its word becomes nonzero.

Software reaches the block through a single-cycle register port inside a 256-byte window. A read returns its data in the same cycle as the request. Only aligned 32-bit words are decoded.

Top module: `core_irq_router`

## Requirements
- R1: After reset, the routing word reads 0, which sends both upstream lines to core 0. Every control register reads 0, which masks every local source. All core IRQ and FIQ outputs are low.
- R2: The routing word is at offset 0x0C. Bits [1:0] pick the core that receives the upstream IRQ, and bits [3:2] pick the core that receives the upstream FIQ. A read returns the two fields in those positions, and all other bits read as 0.
- R3: The timer control registers are at 0x40 + 4*core and the mailbox control registers are at 0x50 + 4*core. A write keeps only bits [7:0], and the upper bits read as 0.
- R4: For local source n (n = 0..3), bit n+4 of its control register selects FIQ delivery. When that bit is set, an active source sets its bit in the FIQ pending word and never in the IRQ pending word, whatever the value of bit n.
- R5: When bit n+4 is clear and bit n is set, an active source sets its bit in the IRQ pending word. When both bits are clear, the source sets no pending bit.
- R6: Pending word layout: bits [3:0] are timer sources 0..3, bits [7:4] are mailboxes 0..3, bit 8 is the upstream line, and bits [31:9] read as 0. Timer source n of core c is input bit 4*c+n, and mailbox n of core c is mailbox vector bit 4*c+n.
- R7: An active upstream IRQ sets bit 8 only in the IRQ pending word of the core named by routing bits [1:0]. An active upstream FIQ sets bit 8 only in the FIQ pending word of the core named by bits [3:2]. The two routes are independent.
- R8: A core's IRQ output (or FIQ output) is high exactly when its IRQ (or FIQ) pending word was nonzero in the previous clock cycle.
- R9: The IRQ pending words are read at 0x60 + 4*core and the FIQ pending words at 0x70 + 4*core. They follow the current input levels and latch nothing, so a bit clears as soon as its source drops.
- R10: A read from any unmapped or misaligned offset returns 0. A write to any unmapped, misaligned or pending-word offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regValid | input | 1 | Register access request this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Byte offset within the window |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the request cycle |
| timerIn | input | 16 | Timer request levels, bit 4*core+source |
| mboxNonzero | input | 16 | Mailbox-nonzero flags, bit 4*core+mailbox |
| upIrq | input | 1 | Shared upstream IRQ level |
| upFiq | input | 1 | Shared upstream FIQ level |
| coreIrq | output | 4 | Per-core IRQ outputs, registered |
| coreFiq | output | 4 | Per-core FIQ outputs, registered |

## Verification
The hardest case to reach is a source whose IRQ-enable bit and FIQ-select bit are both set, while a masked source on the same core is also active. Only the FIQ word may show the source, and the masked one must stay invisible in both words. The stimulus first enables a timer source for IRQ and raises a second, masked timer source. It then rewrites the same control register with both bits set and reads both pending words. The same pass also moves the two upstream lines between cores to show that their routes are independent. It then writes to misaligned and read-only offsets and reads back the registers those writes could have disturbed.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_CORES    = 4;
  localparam int SRC_PER_CORE = 4;
  localparam int CORE_W       = $clog2(NUM_CORES);
  localparam int CTL_W        = 2 * SRC_PER_CORE;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 8;
  localparam int SRC_W        = NUM_CORES * SRC_PER_CORE;
  localparam int UP_BIT       = 2 * SRC_PER_CORE;
  localparam int RSVD_W       = DATA_W - UP_BIT - 1;

  localparam logic [ADDR_W-1:0] OFF_ROUTE = 8'h0C;
  localparam logic [3:0] BANK_TMR = 4'h4;
  localparam logic [3:0] BANK_MBX = 4'h5;
  localparam logic [3:0] BANK_IRQ = 4'h6;
  localparam logic [3:0] BANK_FIQ = 4'h7;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ROUTE, SEL_TMR, SEL_MBX, SEL_IRQ, SEL_FIQ
  } regSel_e;

  typedef struct packed {
    logic              wrRoute;
    logic              wrTmr;
    logic              wrMbx;
    logic [CORE_W-1:0] core;
    regSel_e           rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_router_steer.sv
module irq_router_steer #(
  parameter int N = 4
) (
  input  logic [N-1:0]   active,
  input  logic [2*N-1:0] ctl,
  output logic [N-1:0]   toIrq,
  output logic [N-1:0]   toFiq
);
  for (genvar s = 0; s < N; s++) begin : g_src
    logic fiqSel;
    logic irqEn;
    assign fiqSel   = ctl[s + N];
    assign irqEn    = ctl[s];
    assign toFiq[s] = active[s] & fiqSel;
    assign toIrq[s] = active[s] & irqEn & ~fiqSel;
  end
endmodule

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
(
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strobe
);
  logic [3:0] bank;
  logic       aligned;
  regSel_e    hit;

  assign bank    = regAddr[7:4];
  assign aligned = (regAddr[1:0] == 2'b00);

  always_comb begin
    hit = SEL_NONE;
    if (regAddr == OFF_ROUTE)             hit = SEL_ROUTE;
    else if (aligned && bank == BANK_TMR) hit = SEL_TMR;
    else if (aligned && bank == BANK_MBX) hit = SEL_MBX;
    else if (aligned && bank == BANK_IRQ) hit = SEL_IRQ;
    else if (aligned && bank == BANK_FIQ) hit = SEL_FIQ;
  end

  always_comb begin
    strobe.core    = regAddr[CORE_W+1:2];
    strobe.wrRoute = regValid && regWrite && (hit == SEL_ROUTE);
    strobe.wrTmr   = regValid && regWrite && (hit == SEL_TMR);
    strobe.wrMbx   = regValid && regWrite && (hit == SEL_MBX);
    strobe.rdSel   = (regValid && !regWrite) ? hit : SEL_NONE;
  end
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [CTL_W-1:0]            wrByte,
  input  logic [SRC_W-1:0]            timerIn,
  input  logic [SRC_W-1:0]            mboxIn,
  input  logic                        upIrq,
  input  logic                        upFiq,
  output logic [DATA_W-1:0]           rdData,
  output logic [NUM_CORES*DATA_W-1:0] irqPendFlat,
  output logic [NUM_CORES*DATA_W-1:0] fiqPendFlat,
  output logic [NUM_CORES-1:0]        coreIrq,
  output logic [NUM_CORES-1:0]        coreFiq
);
  logic [CORE_W-1:0] routeIrqCore;
  logic [CORE_W-1:0] routeFiqCore;
  logic [CTL_W-1:0]  tmrCtlArr [NUM_CORES];
  logic [CTL_W-1:0]  mbxCtlArr [NUM_CORES];
  logic [DATA_W-1:0] irqPendArr [NUM_CORES];
  logic [DATA_W-1:0] fiqPendArr [NUM_CORES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeIrqCore <= '0;
      routeFiqCore <= '0;
    end else if (strobe.wrRoute) begin
      routeIrqCore <= wrByte[CORE_W-1:0];
      routeFiqCore <= wrByte[2*CORE_W-1:CORE_W];
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [CTL_W-1:0]        tmrCtlQ;
    logic [CTL_W-1:0]        mbxCtlQ;
    logic [SRC_PER_CORE-1:0] tmrIrq, tmrFiq, mbxIrq, mbxFiq;
    logic                    upIrqHere, upFiqHere;
    logic                    thisCore;

    assign thisCore = (strobe.core == CORE_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tmrCtlQ <= '0;
        mbxCtlQ <= '0;
      end else begin
        if (strobe.wrTmr && thisCore) tmrCtlQ <= wrByte;
        if (strobe.wrMbx && thisCore) mbxCtlQ <= wrByte;
      end
    end

    irq_router_steer #(.N(SRC_PER_CORE)) u_tmr (
      .active(timerIn[c*SRC_PER_CORE +: SRC_PER_CORE]),
      .ctl   (tmrCtlQ),
      .toIrq (tmrIrq),
      .toFiq (tmrFiq)
    );

    irq_router_steer #(.N(SRC_PER_CORE)) u_mbx (
      .active(mboxIn[c*SRC_PER_CORE +: SRC_PER_CORE]),
      .ctl   (mbxCtlQ),
      .toIrq (mbxIrq),
      .toFiq (mbxFiq)
    );

    assign upIrqHere = upIrq && (routeIrqCore == CORE_W'(c));
    assign upFiqHere = upFiq && (routeFiqCore == CORE_W'(c));

    assign irqPendArr[c] = {{RSVD_W{1'b0}}, upIrqHere, mbxIrq, tmrIrq};
    assign fiqPendArr[c] = {{RSVD_W{1'b0}}, upFiqHere, mbxFiq, tmrFiq};
    assign tmrCtlArr[c]  = tmrCtlQ;
    assign mbxCtlArr[c]  = mbxCtlQ;
    assign irqPendFlat[c*DATA_W +: DATA_W] = irqPendArr[c];
    assign fiqPendFlat[c*DATA_W +: DATA_W] = fiqPendArr[c];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        coreIrq[c] <= 1'b0;
        coreFiq[c] <= 1'b0;
      end else begin
        coreIrq[c] <= |irqPendArr[c];
        coreFiq[c] <= |fiqPendArr[c];
      end
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_ROUTE: rdData = DATA_W'({routeFiqCore, routeIrqCore});
      SEL_TMR:   rdData = DATA_W'(tmrCtlArr[strobe.core]);
      SEL_MBX:   rdData = DATA_W'(mbxCtlArr[strobe.core]);
      SEL_IRQ:   rdData = irqPendArr[strobe.core];
      SEL_FIQ:   rdData = fiqPendArr[strobe.core];
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import irq_router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regValid,
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  input  logic [SRC_W-1:0]     timerIn,
  input  logic [SRC_W-1:0]     mboxNonzero,
  input  logic                 upIrq,
  input  logic                 upFiq,
  output logic [NUM_CORES-1:0] coreIrq,
  output logic [NUM_CORES-1:0] coreFiq
);
  ctrlStrobe_t                 strobe;
  logic [NUM_CORES*DATA_W-1:0] irqPendFlat;
  logic [NUM_CORES*DATA_W-1:0] fiqPendFlat;
  logic                        unusedWdataHi;

  assign unusedWdataHi = ^regWdata[DATA_W-1:CTL_W];

  irq_router_ctrl u_ctrl (
    .regValid(regValid),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  irq_router_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrByte     (regWdata[CTL_W-1:0]),
    .timerIn    (timerIn),
    .mboxIn     (mboxNonzero),
    .upIrq      (upIrq),
    .upFiq      (upFiq),
    .rdData     (regRdata),
    .irqPendFlat(irqPendFlat),
    .fiqPendFlat(fiqPendFlat),
    .coreIrq    (coreIrq),
    .coreFiq    (coreFiq)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        regValid,
  input logic                        regWrite,
  input logic [ADDR_W-1:0]           regAddr,
  input logic [DATA_W-1:0]           regRdata,
  input logic [NUM_CORES-1:0]        coreIrq,
  input logic [NUM_CORES-1:0]        coreFiq,
  input logic [NUM_CORES*DATA_W-1:0] irqPendFlat,
  input logic [NUM_CORES*DATA_W-1:0] fiqPendFlat
);
  logic                 isRead, mapped, rdIrqBank, rdFiqBank, rdCtl;
  logic [NUM_CORES-1:0] upIrqBits, upFiqBits, overlap;
  logic                 unusedPend;

  assign isRead    = regValid && !regWrite;
  assign rdIrqBank = isRead && regAddr[7:4] == BANK_IRQ && regAddr[1:0] == 2'b00;
  assign rdFiqBank = isRead && regAddr[7:4] == BANK_FIQ && regAddr[1:0] == 2'b00;
  assign rdCtl     = isRead && (regAddr[7:4] == BANK_TMR || regAddr[7:4] == BANK_MBX)
                     && regAddr[1:0] == 2'b00;
  assign mapped    = regAddr == OFF_ROUTE ||
                     (regAddr[1:0] == 2'b00 && regAddr[7:4] >= BANK_TMR && regAddr[7:4] <= BANK_FIQ);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
    assign upIrqBits[c] = irqPendFlat[c*DATA_W + UP_BIT];
    assign upFiqBits[c] = fiqPendFlat[c*DATA_W + UP_BIT];
    assign overlap[c]   = |(irqPendFlat[c*DATA_W +: UP_BIT] & fiqPendFlat[c*DATA_W +: UP_BIT]);
  end
  assign unusedPend = ^{irqPendFlat, fiqPendFlat};

  p_fiq_wins_r4: assert property (@(posedge clk) disable iff (!rstN) overlap == '0);

  p_up_irq_single_r7: assert property (@(posedge clk) disable iff (!rstN) $onehot0(upIrqBits));

  p_up_fiq_single_r7: assert property (@(posedge clk) disable iff (!rstN) $onehot0(upFiqBits));

  p_irq_out_lag_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdIrqBank |=> coreIrq[$past(regAddr[3:2])] == ($past(regRdata) != '0));

  p_fiq_out_lag_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdFiqBank |=> coreFiq[$past(regAddr[3:2])] == ($past(regRdata) != '0));

  p_route_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && regAddr == OFF_ROUTE) |-> regRdata[DATA_W-1:2*CORE_W] == '0);

  p_ctl_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdCtl |-> regRdata[DATA_W-1:CTL_W] == '0);

  p_pend_upper_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdIrqBank || rdFiqBank) |-> regRdata[DATA_W-1:UP_BIT+1] == '0);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && !mapped) |-> regRdata == '0);
endmodule

bind core_irq_router irq_router_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regValid   (regValid),
  .regWrite   (regWrite),
  .regAddr    (regAddr),
  .regRdata   (regRdata),
  .coreIrq    (coreIrq),
  .coreFiq    (coreFiq),
  .irqPendFlat(irqPendFlat),
  .fiqPendFlat(fiqPendFlat)
);

// File: tb/sim_core_irq_router.sv
module sim_core_irq_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [15:0] timerIn = '0;
  logic [15:0] mboxNonzero = '0;
  logic        upIrq = 1'b0;
  logic        upFiq = 1'b0;
  logic [3:0]  coreIrq, coreFiq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  core_irq_router u0 (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .timerIn(timerIn), .mboxNonzero(mboxNonzero), .upIrq(upIrq), .upFiq(upFiq),
    .coreIrq(coreIrq), .coreFiq(coreFiq)
  );

  // Monitor: compares due items 5 ns after the falling edge
  always @(negedge clk) begin
    #5;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic [31:0] act;
        act = (q[i].kind == 0) ? regRdata : {24'h0, coreFiq, coreIrq};
        checks++;
        if (act !== q[i].exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", q[i].tag, act, q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    q.push_back('{cyc, 0, e, tag});
  endtask

  task automatic drive(input logic [15:0] t, input logic [15:0] m, input logic ui, input logic uf);
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    timerIn = t; mboxNonzero = m; upIrq = ui; upFiq = uf;
  endtask

  // expected {fiq,irq} outputs, checked d cycles from now
  task automatic expectOut(input logic [3:0] irqE, input logic [3:0] fiqE, input int d, input string tag);
    q.push_back('{cyc + d, 1, {24'h0, fiqE, irqE}, tag});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(8'h0C, 32'h0, "R1 route");
    expectOut(4'h0, 4'h0, 0, "R1 outputs");
    rd(8'h40, 32'h0, "R1 tmr ctl");
    rd(8'h54, 32'h0, "R1 mbx ctl");
    // R3 width of control registers
    wr(8'h44, 32'hFFFF_FF0F);
    rd(8'h44, 32'h0000_000F, "R3 tmr ctl low byte");
    wr(8'h5C, 32'h1234_56A5);
    rd(8'h5C, 32'h0000_00A5, "R3 mbx ctl low byte");
    wr(8'h44, 32'h0); wr(8'h5C, 32'h0);
    // R2 routing word
    wr(8'h0C, 32'hFFFF_FFF9);
    rd(8'h0C, 32'h9, "R2 route readback");
    // R7 upstream steering: irq->core1, fiq->core2
    drive(16'h0, 16'h0, 1'b1, 1'b0);
    expectOut(4'b0010, 4'b0000, 1, "R7 upIrq to core1");
    rd(8'h64, 32'h100, "R6 upstream bit 8");
    drive(16'h0, 16'h0, 1'b1, 1'b1);
    expectOut(4'b0010, 4'b0100, 1, "R7 upFiq to core2");
    rd(8'h78, 32'h100, "R7 fiq word core2");
    wr(8'h0C, 32'hC);
    expectOut(4'b0001, 4'b1000, 2, "R7 reroute");
    rd(8'h60, 32'h100, "R7 irq word core0");
    drive(16'h0, 16'h0, 1'b0, 1'b0);
    // R5 / R8: timer source 0 of core0 enabled for IRQ
    wr(8'h40, 32'h01);
    drive(16'h0001, 16'h0, 1'b0, 1'b0);
    expectOut(4'b0000, 4'b0000, 0, "R8 before edge");
    expectOut(4'b0001, 4'b0000, 1, "R8 one clock later");
    rd(8'h60, 32'h1, "R5 irq enable");
    drive(16'h0005, 16'h0, 1'b0, 1'b0);
    rd(8'h60, 32'h1, "R5 masked source 2");
    rd(8'h70, 32'h0, "R5 masked not in fiq");
    // R4 FIQ select wins
    wr(8'h40, 32'h11);
    expectOut(4'b0000, 4'b0001, 2, "R4 outputs");
    rd(8'h60, 32'h0, "R4 not in irq");
    rd(8'h70, 32'h1, "R4 in fiq");
    // R6 mailbox layout on core2
    wr(8'h58, 32'h82);
    drive(16'h0005, 16'h0A00, 1'b0, 1'b0);
    expectOut(4'b0100, 4'b0101, 1, "R6 mailbox outputs");
    rd(8'h68, 32'h20, "R6 mailbox1 irq bit5");
    rd(8'h78, 32'h80, "R6 mailbox3 fiq bit7");
    // R9 levels not latched
    drive(16'h0, 16'h0, 1'b0, 1'b0);
    rd(8'h68, 32'h0, "R9 irq word clears");
    rd(8'h70, 32'h0, "R9 fiq word clears");
    expectOut(4'b0000, 4'b0000, 0, "R9 outputs clear");
    // R10 unmapped space
    rd(8'h00, 32'h0, "R10 offset 0x00");
    rd(8'h80, 32'h0, "R10 offset 0x80");
    rd(8'hFC, 32'h0, "R10 offset 0xFC");
    rd(8'h41, 32'h0, "R10 misaligned read");
    wr(8'h0D, 32'h5);
    rd(8'h0C, 32'hC, "R10 misaligned write ignored");
    wr(8'h3C, 32'hFF);
    rd(8'h40, 32'h11, "R10 unmapped write ignored");
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, 32'h0, "R10 pending word read-only");
    rd(8'h0C, 32'hC, "R10 route intact");
    drive(16'h0, 16'h0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    done = 1;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard actual=%0d expected=0 pending items", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule